// File: doc/BRIEF.md
# Chunked Flash Read Sequencer

This block is a hardware master that fetches an arbitrary span of bytes from a serial flash. It sits in front of a flash command engine, the unit that shifts opcodes, addresses and data to the device and collects returned words in a small word FIFO. A request is a start pulse with a byte offset and a byte length. The sequencer then works on its own. It claims the flash lock, cuts the span into pieces that each fit inside one FIFO window, and reads each piece with a fast-read command. It emits the returned data as byte-ordered words, releases the lock, and pulses `done` with a result code.

Before every piece, the sequencer empties stale FIFO words and reads the device status byte. If the device reports a write still in progress, the piece is not read. Every wait has its own bounded retry limit, set by a parameter: the lock, the status command, the FIFO drain and the read command. When any step fails, the lock is still handed back before `done`.

Top module: `flash_rd_seq`

## Requirements
- R1: The lock is claimed by pulsing `sem_rd` once per cycle while `sem_locked` is high. The first `sem_rd` cycle with `sem_locked` low takes ownership. No further `sem_rd` pulse follows in that request.
- R2: If `sem_rd` sees `sem_locked` high SEM_TRIES times in a row, the request ends with error code 6. No command is issued and no `sem_rel` pulse follows.
- R3: Each fast read covers the bytes from the current address up to the next FIFO_BYTES-aligned boundary (default 128), cut short by the bytes still owed. The address starts at `start_addr`, advances by each piece, and wraps at 24 bits.
- R4: A piece whose length is zero, above FIFO_BYTES or not a multiple of 4 ends the request with error code 1, and no fast read is issued for it.
- R5: Before each piece, any words held in the FIFO are popped until `fifo_cnt` reads zero. Then a status command is issued: opcode 0x05, 4 read bytes, 0 address bytes.
- R6: If the FIFO is empty when the status command finishes, the flush and the status command are repeated once. A second empty result ends the request with error code 3.
- R7: The status byte is bits 31:24 of the returned word. If its bit 0 is set, the request ends with error code 2 and no fast read.
- R8: Each wait gives up after a fixed number of cycles in which it sees no progress. The status command gives up after CHECK_MAX cycles with `cmd_active` high (error 4). The FIFO flush gives up after CHECK_MAX cycles with `fifo_cnt` non-zero (error 5). The fast read gives up after BLOCK_MAX cycles with `cmd_active` high (error 7).
- R9: A fast read uses opcode 0x0B with 4 address bytes and the piece length as read bytes. It is followed by exactly length/4 words on `out_word`, each byte-reversed: `out_word[7:0]` is the first flash byte, taken from `fifo_rdata[31:23+1]`.
- R10: Once the lock is owned, exactly one `sem_rel` pulse is given before `done`, for a clean result and for every error.
- R11: `done` is a one-cycle pulse. `err_code` (0 = success) keeps its value from `done` until the next accepted start. A start pulse during a request is ignored.
- R12: A zero-length request claims and releases the lock, issues no command and finishes with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| start_addr | input | 24 | Byte offset of the first byte |
| start_len | input | LEN_W | Byte count of the request |
| done | output | 1 | One-cycle end-of-request pulse |
| err_code | output | 3 | Result of the last request |
| out_valid | output | 1 | `out_word` carries data |
| out_word | output | 32 | Four flash bytes, first byte in bits 7:0 |
| sem_rd | output | 1 | Lock read attempt |
| sem_locked | input | 1 | Lock read result, high when held elsewhere |
| sem_rel | output | 1 | Lock release (write zero) |
| cmd_go | output | 1 | Issue a command to the engine |
| cmd_op | output | 8 | Command opcode |
| cmd_rd_bytes | output | 9 | Bytes to read back |
| cmd_addr_bytes | output | 4 | Address bytes to send |
| cmd_addr | output | 24 | Flash byte address |
| cmd_active | input | 1 | Engine still running the last command |
| fifo_cnt | input | FCNT_W | Words waiting in the engine FIFO |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Remove the head word |

## Verification
The properties assume an engine that is well behaved. After `cmd_go` it keeps `cmd_active` high until the command's words are in the FIFO. It never raises `cmd_active` on its own, and it holds at least length/4 words once a fast read has finished. Its lock only reports ownership to one reader. The bench engine model follows these rules in every case. Stuck or late behaviour is produced only through its own knobs: a FIFO that ignores pops, a status command that returns nothing, a long active phase, and a lock that refuses a set number of reads. With these knobs, every error path is reached without the engine breaking the command protocol.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [2:0] {
    FRS_OK       = 3'd0,
    FRS_E_LEN    = 3'd1,
    FRS_E_WIP    = 3'd2,
    FRS_E_BUSY   = 3'd3,
    FRS_E_CMD_TO = 3'd4,
    FRS_E_FIFO   = 3'd5,
    FRS_E_SEM    = 3'd6,
    FRS_E_RD_TO  = 3'd7
  } frs_err_e;

  localparam logic [7:0] FRS_OP_STATUS    = 8'h05;
  localparam logic [7:0] FRS_OP_FAST_READ = 8'h0B;
  localparam logic [3:0] FRS_READ_ADDR_B  = 4'd4;
  localparam logic [8:0] FRS_STATUS_RD_B  = 9'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_SEM, S_PLAN, S_FL_CHK, S_FL_POP, S_FL_WAIT,
    S_ST_CMD, S_ST_POLL, S_ST_GET, S_WIP, S_RD_CMD, S_RD_POLL,
    S_DRAIN, S_NEXT, S_REL, S_FIN
  } frs_state_e;

  typedef enum logic [1:0] {
    RT_STATUS,
    RT_WIP,
    RT_NEXT
  } frs_ret_e;

endpackage

// File: rtl/frs_chunk_plan.sv
module frs_chunk_plan #(
  parameter int FIFO_BYTES = 128,
  parameter int LEN_W      = 16,
  localparam int OFF_W     = $clog2(FIFO_BYTES),
  localparam int CW        = OFF_W + 1
) (
  input  logic [OFF_W-1:0] addr_lo,
  input  logic [LEN_W-1:0] remain,
  output logic [CW-1:0]    chunk_len,
  output logic             chunk_bad
);
  logic [CW-1:0] room;

  always_comb begin
    room = CW'(FIFO_BYTES) - CW'(addr_lo);
    if (remain < LEN_W'(room)) chunk_len = CW'(remain);
    else                       chunk_len = room;
    chunk_bad = (chunk_len == '0) || (chunk_len > CW'(FIFO_BYTES)) ||
                (chunk_len[1:0] != 2'b00);
  end
endmodule

// File: rtl/frs_poll_limit.sv
module frs_poll_limit #(
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic [PCW-1:0] limit,
  output logic           last
);
  logic [PCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = clr | step;
    cnt_d  = clr ? '0 : cnt_q + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == limit - PCW'(1));
endmodule

// File: rtl/frs_word_swap.sv
module frs_word_swap #(
  parameter int NBYTES = 4
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[8*i +: 8] = din[8*(NBYTES-1-i) +: 8];
  end
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import frs_pkg::*;
#(
  parameter int FIFO_BYTES = 128,
  parameter int LEN_W      = 16,
  parameter int FCNT_W     = 6,
  parameter int SEM_TRIES  = 500,
  parameter int CHECK_MAX  = 10000,
  parameter int BLOCK_MAX  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              sem_rd,
  input  logic              sem_locked,
  output logic              sem_rel,
  output logic              cmd_go,
  output logic [7:0]        cmd_op,
  output logic [8:0]        cmd_rd_bytes,
  output logic [3:0]        cmd_addr_bytes,
  output logic [23:0]       cmd_addr,
  input  logic              cmd_active,
  input  logic [FCNT_W-1:0] fifo_cnt,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_pop
);
  localparam int OFF_W = $clog2(FIFO_BYTES);
  localparam int CW    = OFF_W + 1;
  localparam int MAX_A = (SEM_TRIES > CHECK_MAX) ? SEM_TRIES : CHECK_MAX;
  localparam int MAX_L = (MAX_A > BLOCK_MAX) ? MAX_A : BLOCK_MAX;
  localparam int PCW   = $clog2(MAX_L + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  frs_state_e        state_q, state_d;
  frs_ret_e          ret_q, ret_d;
  frs_err_e          err_q, err_d;
  logic [23:0]       addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CW-1:0]     chunk_q, chunk_d;
  logic [CW-1:0]     words_q, words_d;
  logic [FCNT_W-1:0] flush_q, flush_d;
  logic              retried_q, retried_d;
  logic              wip_q, wip_d;

  logic [CW-1:0]  plan_len;
  logic           plan_bad;
  logic           poll_step, poll_clr, poll_last;
  logic [PCW-1:0] poll_lim;
  frs_state_e     ret_state;

  frs_chunk_plan #(.FIFO_BYTES(FIFO_BYTES), .LEN_W(LEN_W)) u_plan (
    .addr_lo  (addr_q[OFF_W-1:0]),
    .remain   (rem_q),
    .chunk_len(plan_len),
    .chunk_bad(plan_bad)
  );

  frs_poll_limit #(.PCW(PCW)) u_poll (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (poll_clr),
    .step (poll_step),
    .limit(poll_lim),
    .last (poll_last)
  );

  frs_word_swap #(.NBYTES(4)) u_swap (
    .din (fifo_rdata),
    .dout(out_word)
  );

  always_comb begin
    unique case (ret_q)
      RT_STATUS: ret_state = S_ST_CMD;
      RT_WIP:    ret_state = S_WIP;
      default:   ret_state = S_NEXT;
    endcase
  end

  // next-state and output decode
  always_comb begin
    state_d        = state_q;
    ret_d          = ret_q;
    err_d          = err_q;
    addr_d         = addr_q;
    rem_d          = rem_q;
    chunk_d        = chunk_q;
    words_d        = words_q;
    flush_d        = flush_q;
    retried_d      = retried_q;
    wip_d          = wip_q;
    sem_rd         = 1'b0;
    sem_rel        = 1'b0;
    cmd_go         = 1'b0;
    cmd_op         = FRS_OP_STATUS;
    cmd_rd_bytes   = FRS_STATUS_RD_B;
    cmd_addr_bytes = 4'd0;
    fifo_pop       = 1'b0;
    out_valid      = 1'b0;
    done           = 1'b0;
    poll_step      = 1'b0;
    poll_lim       = PCW'(CHECK_MAX);

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          addr_d  = start_addr;
          rem_d   = start_len;
          err_d   = FRS_OK;
          state_d = S_SEM;
        end
      end
      S_SEM: begin
        poll_lim = PCW'(SEM_TRIES);
        sem_rd   = 1'b1;
        if (!sem_locked) begin
          state_d = (rem_q == '0) ? S_REL : S_PLAN;
        end else if (poll_last) begin
          err_d   = FRS_E_SEM;
          state_d = S_FIN;
        end else begin
          poll_step = 1'b1;
        end
      end
      S_PLAN: begin
        if (plan_bad) begin
          err_d   = FRS_E_LEN;
          state_d = S_REL;
        end else begin
          chunk_d   = plan_len;
          retried_d = 1'b0;
          ret_d     = RT_STATUS;
          state_d   = S_FL_CHK;
        end
      end
      S_FL_CHK: begin
        if (fifo_cnt == '0) begin
          state_d = ret_state;
        end else begin
          flush_d = fifo_cnt;
          state_d = S_FL_POP;
        end
      end
      S_FL_POP: begin
        fifo_pop = 1'b1;
        flush_d  = flush_q - FCNT_W'(1);
        if (flush_q == FCNT_W'(1)) state_d = S_FL_WAIT;
      end
      S_FL_WAIT: begin
        if (fifo_cnt == '0) begin
          state_d = ret_state;
        end else if (poll_last) begin
          err_d   = FRS_E_FIFO;
          state_d = S_REL;
        end else begin
          poll_step = 1'b1;
        end
      end
      S_ST_CMD: begin
        cmd_go  = 1'b1;
        state_d = S_ST_POLL;
      end
      S_ST_POLL: begin
        if (!cmd_active) begin
          state_d = S_ST_GET;
        end else if (poll_last) begin
          err_d   = FRS_E_CMD_TO;
          state_d = S_REL;
        end else begin
          poll_step = 1'b1;
        end
      end
      S_ST_GET: begin
        if (fifo_cnt == '0) begin
          if (!retried_q) begin
            retried_d = 1'b1;
            ret_d     = RT_STATUS;
            state_d   = S_FL_CHK;
          end else begin
            err_d   = FRS_E_BUSY;
            state_d = S_REL;
          end
        end else begin
          fifo_pop = 1'b1;
          wip_d    = fifo_rdata[24];
          ret_d    = RT_WIP;
          state_d  = S_FL_CHK;
        end
      end
      S_WIP: begin
        if (wip_q) begin
          err_d   = FRS_E_WIP;
          state_d = S_REL;
        end else begin
          state_d = S_RD_CMD;
        end
      end
      S_RD_CMD: begin
        cmd_go         = 1'b1;
        cmd_op         = FRS_OP_FAST_READ;
        cmd_rd_bytes   = 9'(chunk_q);
        cmd_addr_bytes = FRS_READ_ADDR_B;
        words_d        = chunk_q >> 2;
        state_d        = S_RD_POLL;
      end
      S_RD_POLL: begin
        poll_lim = PCW'(BLOCK_MAX);
        if (!cmd_active) begin
          state_d = S_DRAIN;
        end else if (poll_last) begin
          err_d   = FRS_E_RD_TO;
          state_d = S_REL;
        end else begin
          poll_step = 1'b1;
        end
      end
      S_DRAIN: begin
        fifo_pop  = 1'b1;
        out_valid = 1'b1;
        words_d   = words_q - CW'(1);
        if (words_q == CW'(1)) begin
          ret_d   = RT_NEXT;
          state_d = S_FL_CHK;
        end
      end
      S_NEXT: begin
        addr_d  = addr_q + 24'(chunk_q);
        rem_d   = rem_q - LEN_W'(chunk_q);
        state_d = (rem_q == LEN_W'(chunk_q)) ? S_REL : S_PLAN;
      end
      S_REL: begin
        sem_rel = 1'b1;
        state_d = S_FIN;
      end
      S_FIN: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign poll_clr = (state_d != state_q);
  assign cmd_addr = addr_q;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= S_IDLE;
      ret_q     <= RT_STATUS;
      err_q     <= FRS_OK;
      addr_q    <= '0;
      rem_q     <= '0;
      chunk_q   <= '0;
      words_q   <= '0;
      flush_q   <= '0;
      retried_q <= 1'b0;
      wip_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ret_q     <= ret_d;
      err_q     <= err_d;
      addr_q    <= addr_d;
      rem_q     <= rem_d;
      chunk_q   <= chunk_d;
      words_q   <= words_d;
      flush_q   <= flush_d;
      retried_q <= retried_d;
      wip_q     <= wip_d;
    end
  end
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int FIFO_BYTES = 128,
  localparam int OFF_W     = $clog2(FIFO_BYTES)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic [2:0]  err_code,
  input logic        out_valid,
  input logic        sem_rd,
  input logic        sem_locked,
  input logic        sem_rel,
  input logic        cmd_go,
  input logic [7:0]  cmd_op,
  input logic [8:0]  cmd_rd_bytes,
  input logic [3:0]  cmd_addr_bytes,
  input logic [23:0] cmd_addr,
  input logic        cmd_active
);
  logic held_q, run_q, stat_q;
  logic is_rd, is_st;
  logic [9:0] rd_end;

  assign is_rd  = cmd_go && (cmd_op == 8'h0B);
  assign is_st  = cmd_go && (cmd_op == 8'h05);
  assign rd_end = 10'(cmd_addr[OFF_W-1:0]) + 10'(cmd_rd_bytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      run_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (sem_rd && !sem_locked) held_q <= 1'b1;
      else if (sem_rel)          held_q <= 1'b0;
      if (start && !run_q) run_q <= 1'b1;
      else if (done)       run_q <= 1'b0;
      if (is_st)      stat_q <= 1'b1;
      else if (is_rd) stat_q <= 1'b0;
    end
  end

  a_r1_no_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
    sem_rd |-> !held_q);
  a_r10_release_owned: assert property (@(posedge clk) disable iff (!rst_n)
    sem_rel |-> held_q);
  a_r10_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !held_q);
  a_r9_data_owned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> held_q);
  a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> (rd_end <= 10'(FIFO_BYTES)));
  a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> (cmd_rd_bytes != 9'd0 && cmd_rd_bytes[1:0] == 2'b00 &&
               cmd_addr_bytes == 4'd4));
  a_r5_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> stat_q);
  a_r5_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    is_st |-> (cmd_rd_bytes == 9'd4 && cmd_addr_bytes == 4'd0));
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !cmd_active);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(err_code));
endmodule

bind flash_rd_seq frs_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .done          (done),
  .err_code      (err_code),
  .out_valid     (out_valid),
  .sem_rd        (sem_rd),
  .sem_locked    (sem_locked),
  .sem_rel       (sem_rel),
  .cmd_go        (cmd_go),
  .cmd_op        (cmd_op),
  .cmd_rd_bytes  (cmd_rd_bytes),
  .cmd_addr_bytes(cmd_addr_bytes),
  .cmd_addr      (cmd_addr),
  .cmd_active    (cmd_active)
);

// File: tb/flash_rd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_rd_seq_tb_top;
  localparam int F  = 32;
  localparam int LW = 16;
  localparam int FW = 6;

  logic clk, rst_n, start;
  logic [23:0] start_addr;
  logic [LW-1:0] start_len;
  logic done, out_valid, sem_rd, sem_rel, cmd_go, fifo_pop;
  logic [2:0] err_code;
  logic [31:0] out_word, fifo_rdata;
  logic [7:0] cmd_op;
  logic [8:0] cmd_rd_bytes;
  logic [3:0] cmd_addr_bytes;
  logic [23:0] cmd_addr;
  logic sem_locked, cmd_active;
  logic [FW-1:0] fifo_cnt;

  flash_rd_seq #(.FIFO_BYTES(F), .LEN_W(LW), .FCNT_W(FW), .SEM_TRIES(5),
                 .CHECK_MAX(8), .BLOCK_MAX(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .done(done), .err_code(err_code),
    .out_valid(out_valid), .out_word(out_word), .sem_rd(sem_rd),
    .sem_locked(sem_locked), .sem_rel(sem_rel), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_rd_bytes(cmd_rd_bytes),
    .cmd_addr_bytes(cmd_addr_bytes), .cmd_addr(cmd_addr),
    .cmd_active(cmd_active), .fifo_cnt(fifo_cnt), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // engine knobs, written only at negedge
  int st_delay, rd_delay, busy_left, refuse_n, junk_n;
  bit stuck, junk_req;
  logic [7:0] stat_byte;

  // engine state and logs
  logic [31:0] fa [0:63];
  int wp, rp, act, p_len;
  logic [7:0] p_op;
  logic [23:0] p_addr;
  int n_out, n_rd, n_st, n_semrd, n_rel;
  logic [31:0] out_buf [0:255];
  logic [23:0] rd_a [0:63];
  int rd_l [0:63];

  function automatic logic [7:0] mb(input logic [23:0] a);
    return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] mword(input logic [23:0] a);
    return {mb(a), mb(24'(a + 24'd1)), mb(24'(a + 24'd2)), mb(24'(a + 24'd3))};
  endfunction

  assign cmd_active = (act != 0);
  assign fifo_cnt   = FW'(wp - rp);
  assign fifo_rdata = fa[rp % 64];
  assign sem_locked = (refuse_n > 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      wp <= 0; rp <= 0; act <= 0;
    end else begin
      if (fifo_pop && (wp != rp) && !stuck) rp <= rp + 1;
      if (sem_rd) begin
        n_semrd <= n_semrd + 1;
        if (refuse_n > 0) refuse_n <= refuse_n - 1;
      end
      if (sem_rel) n_rel <= n_rel + 1;
      if (out_valid) begin
        out_buf[n_out % 256] <= out_word;
        n_out <= n_out + 1;
      end
      if (junk_req) begin
        for (int k = 0; k < junk_n; k++) fa[(wp + k) % 64] <= 32'hDEAD0000 + k;
        wp <= wp + junk_n;
      end else if (cmd_go) begin
        p_op <= cmd_op; p_addr <= cmd_addr; p_len <= int'(cmd_rd_bytes);
        if (cmd_op == 8'h05) begin
          act <= st_delay + 1; n_st <= n_st + 1;
        end else begin
          act <= rd_delay + 1;
          rd_a[n_rd % 64] <= cmd_addr; rd_l[n_rd % 64] <= int'(cmd_rd_bytes);
          n_rd <= n_rd + 1;
        end
      end else if (act != 0) begin
        act <= act - 1;
        if (act == 1) begin
          if (p_op == 8'h05) begin
            if (busy_left > 0) busy_left <= busy_left - 1;
            else begin
              fa[wp % 64] <= {stat_byte, 24'h0};
              wp <= wp + 1;
            end
          end else begin
            for (int k = 0; k < p_len / 4; k++)
              fa[(wp + k) % 64] <= mword(24'(p_addr + 24'(4 * k)));
            wp <= wp + p_len / 4;
          end
        end
      end
    end
  end

  int n_chk, n_err;
  bit timed_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  task automatic run(input logic [23:0] a, input int len, input bit poke);
    int t;
    @(negedge clk);
    n_out = 0; n_rd = 0; n_st = 0; n_semrd = 0; n_rel = 0;
    start = 1'b1; start_addr = a; start_len = LW'(len);
    if (junk_n > 0) junk_req = 1'b1;
    @(negedge clk);
    start = 1'b0; junk_req = 1'b0; junk_n = 0;
    t = 0;
    while (!done && t < 4000) begin
      if (poke && t == 6) begin
        start = 1'b1; start_addr = 24'h000100; start_len = LW'(8);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(done, "R11", "done seen", done, 1);
  endtask

  // full check of a clean request
  task automatic check_clean(input logic [23:0] a, input int len, input string tag);
    int r, c, nch;
    logic [23:0] ca;
    bit ok;
    logic [31:0] e;
    chk(err_code == 3'd0, "R11", {tag, " code"}, err_code, 0);
    chk(n_out == len / 4, "R9", {tag, " word count"}, n_out, len / 4);
    ok = 1'b1;
    for (int k = 0; k < len / 4 && k < n_out; k++) begin
      e = {mb(24'(a + 24'(4*k+3))), mb(24'(a + 24'(4*k+2))),
           mb(24'(a + 24'(4*k+1))), mb(24'(a + 24'(4*k)))};
      if (out_buf[k] != e && ok) begin
        ok = 1'b0;
        chk(1'b0, "R9", {tag, " data"}, out_buf[k], e);
      end
    end
    if (ok) chk(1'b1, "R9", {tag, " data"}, 0, 0);
    r = len; ca = a; nch = 0; ok = 1'b1;
    while (r > 0) begin
      c = F - int'(ca % F);
      if (c > r) c = r;
      if (nch < n_rd && (rd_a[nch] != ca || rd_l[nch] != c) && ok) begin
        ok = 1'b0;
        chk(1'b0, "R3", {tag, " piece"}, {rd_a[nch], 8'(rd_l[nch])}, {ca, 8'(c)});
      end
      ca = 24'(ca + 24'(c)); r -= c; nch++;
    end
    if (ok) chk(n_rd == nch, "R3", {tag, " piece count"}, n_rd, nch);
    chk(n_st == nch, "R5", {tag, " status per piece"}, n_st, nch);
    chk(n_rel == 1, "R10", {tag, " release"}, n_rel, 1);
    chk(n_semrd == 1, "R1", {tag, " lock reads"}, n_semrd, 1);
  endtask

  task automatic check_err(input int code, input int rel, input string req, input string tag);
    chk(err_code == 3'(code), req, {tag, " code"}, err_code, code);
    chk(n_rel == rel, "R10", {tag, " release"}, n_rel, rel);
  endtask

  initial begin
    n_chk = 0; n_err = 0; timed_out = 1'b0;
    start = 1'b0; start_addr = '0; start_len = '0;
    st_delay = 1; rd_delay = 3; busy_left = 0; refuse_n = 0; junk_n = 0;
    stuck = 1'b0; junk_req = 1'b0; stat_byte = 8'h00;
    n_out = 0; n_rd = 0; n_st = 0; n_semrd = 0; n_rel = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && err_code == 3'd0 && !out_valid && !sem_rd && !cmd_go,
        "R11", "reset state", {done, err_code, out_valid, sem_rd, cmd_go}, 0);

    // R3 R5 R9 R10: sweep of offsets and lengths
    for (int off = 0; off < 2 * F; off += 4)
      for (int len = 4; len <= 100; len += 4) begin
        run(24'(off), len, 1'b0);
        check_clean(24'(off), len, "sweep");
      end

    // R3: 24-bit wrap
    run(24'hFFFFF8, 16, 1'b0);
    check_clean(24'hFFFFF8, 16, "wrap");

    // R12: zero length
    run(24'h10, 0, 1'b0);
    chk(err_code == 0 && n_st == 0 && n_rd == 0, "R12", "zero length",
        {err_code, 8'(n_st), 8'(n_rd)}, 0);
    chk(n_semrd == 1 && n_rel == 1, "R12", "zero length lock", {n_semrd, n_rel}, {1, 1});

    // R1: lock refused four times, then taken
    refuse_n = 4;
    run(24'h40, 12, 1'b0);
    chk(err_code == 0, "R1", "late lock code", err_code, 0);
    chk(n_semrd == 5, "R1", "late lock reads", n_semrd, 5);
    // R2: lock never granted
    refuse_n = 5;
    run(24'h40, 12, 1'b0);
    check_err(6, 0, "R2", "no lock");
    chk(n_semrd == 5 && n_st == 0, "R2", "no lock traffic", {n_semrd, n_st}, {5, 0});
    refuse_n = 0;

    // R4: illegal pieces
    run(24'h2, 40, 1'b0);
    check_err(1, 1, "R4", "odd offset");
    chk(n_rd == 0, "R4", "odd offset reads", n_rd, 0);
    run(24'h0, 6, 1'b0);
    check_err(1, 1, "R4", "odd length");
    run(24'h0, 34, 1'b0);
    check_err(1, 1, "R4", "odd tail");
    chk(n_out == 8 && n_rd == 1, "R4", "odd tail first piece", {n_out, n_rd}, {8, 1});

    // R5: stale words flushed
    junk_n = 3;
    run(24'h24, 20, 1'b0);
    check_clean(24'h24, 20, "stale words");
    // R8: flush that never drains
    junk_n = 2; stuck = 1'b1;
    run(24'h0, 8, 1'b0);
    check_err(5, 1, "R8", "stuck fifo");
    stuck = 1'b0;

    // R6: busy once then good, busy twice fails
    busy_left = 1;
    run(24'h8, 8, 1'b0);
    chk(err_code == 0 && n_st == 2, "R6", "single busy", {err_code, 8'(n_st)}, {3'd0, 8'd2});
    busy_left = 2;
    run(24'h8, 8, 1'b0);
    check_err(3, 1, "R6", "double busy");
    chk(n_rd == 0, "R6", "double busy reads", n_rd, 0);
    busy_left = 0;

    // R7: write in progress
    stat_byte = 8'h01;
    run(24'h8, 8, 1'b0);
    check_err(2, 1, "R7", "write in progress");
    chk(n_rd == 0 && n_out == 0, "R7", "no read", {n_rd, n_out}, 0);
    repeat (20) @(negedge clk);
    chk(err_code == 3'd2, "R11", "code held", err_code, 2);
    stat_byte = 8'hFE;
    run(24'h8, 8, 1'b0);
    check_clean(24'h8, 8, "other status bits");
    stat_byte = 8'h00;

    // R8: status and read wait limits
    st_delay = 6;
    run(24'h0, 8, 1'b0);
    check_clean(24'h0, 8, "slow status");
    st_delay = 7;
    run(24'h0, 8, 1'b0);
    check_err(4, 1, "R8", "status timeout");
    st_delay = 1;
    rd_delay = 14;
    run(24'h0, 8, 1'b0);
    check_clean(24'h0, 8, "slow read");
    rd_delay = 15;
    run(24'h0, 8, 1'b0);
    check_err(7, 1, "R8", "read timeout");
    rd_delay = 3;
    repeat (30) @(negedge clk);

    // R11: start during a request is ignored
    run(24'h30, 48, 1'b1);
    check_clean(24'h30, 48, "R11 restart ignored");
    @(negedge clk);
    chk(!done, "R11", "done one cycle", done, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    timed_out = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule